// File: doc/BRIEF.md
# Transmit Word Queue with Parity Insertion

This block sits between a 16-bit host bus and a serial transmitter. The host builds each 32-bit word in two writes. A low-half strobe latches bits 15..0. A high-half strobe then supplies bits 31..16, and in that same clock edge the complete word is committed into a 32-entry first-in first-out store. When parity insertion is on, bit 31 of the committed word is replaced by a generated parity bit computed over bits 30..0. When it is off, all 32 bits are kept as loaded.

The oldest stored word is always presented on `txWord`, ready for a parallel-load shift register. A pop request retires that word. Three flags let the host pace its writes:
- `txReady` reports an empty queue.
- `roomForBlock` reports that a 16-word block can be written.
- `fifoFull` reports that no slot is free.

Top module: `txParityFifo`

## Requirements
- R1: After reset, `txReady`=1, `roomForBlock`=1 and `fifoFull`=0.
- R2: A `loadLow` pulse latches `hostData` as bits 15..0. A following `loadHigh` pulse takes `hostData` as bits 31..16 and commits the word at that same clock edge.
- R3: With 32 words stored, `fifoFull`=1. A commit attempted while full, without a pop in the same cycle, is dropped, and the stored contents and order are unchanged.
- R4: With `parityOn`=1 and `parityEven`=0 at the commit edge, bit 31 of the stored word makes the count of ones in bits 31..0 odd. The loaded bit 31 is discarded.
- R5: With `parityOn`=1 and `parityEven`=1 at the commit edge, bit 31 makes the count of ones in bits 31..0 even.
- R6: With `parityOn`=0 at the commit edge, all 32 loaded bits are stored unchanged.
- R7: `txReady` is 1 exactly when no word is stored.
- R8: `roomForBlock` is 1 exactly when fewer than 16 words are stored.
- R9: `txWord` shows the oldest stored word. A `popReq` on a non-empty queue retires it, and the next word then appears.
- R10: A `loadHigh` with no pending low half commits nothing. A second `loadLow` replaces the pending low half. A `loadLow` on its own leaves every flag unchanged.
- R11: A `popReq` on an empty queue has no effect.
- R12: When the queue is full, a commit and a pop in the same cycle are both carried out. The queue stays full, the head advances, and the new word goes to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| hostData | input | 16 | Host half-word bus |
| loadLow | input | 1 | Latch low half (bits 15..0) |
| loadHigh | input | 1 | Supply high half (bits 31..16) and commit |
| parityEven | input | 1 | 0 = odd parity, 1 = even parity |
| parityOn | input | 1 | 1 = bit 31 is generated parity |
| popReq | input | 1 | Retire the head word |
| txWord | output | 32 | Oldest stored word (valid when `txReady`=0) |
| txReady | output | 1 | Queue empty |
| roomForBlock | output | 1 | Fewer than 16 words stored |
| fifoFull | output | 1 | All 32 slots occupied |

## Verification
Commit and retire can land in the same cycle. The case that matters is a full queue, where a naive design would drop the write. The bench fills all 32 slots, latches a low half, and then raises `loadHigh` and `popReq` in one cycle. It judges the result by three observations: `fifoFull` must stay high, the head must move on to the second-oldest word, and draining the queue must return the new word last. A lone commit attempt on a full queue is also made, and draining must show that it vanished.

// File: rtl/txFifoPkg.sv
package txFifoPkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic latchLow;     // capture the low half-word
    logic writeEn;      // commit the assembled word at the tail
    logic readAdvance;  // retire the head word
  } fifoStrobe_t;
endpackage

// File: rtl/txFifoCtrl.sv
module txFifoCtrl
  import txFifoPkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadLow,
  input  logic        loadHigh,
  input  logic        popReq,
  output fifoStrobe_t strobes,
  output logic        txReady,
  output logic        roomForBlock,
  output logic        fifoFull
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] count;
  logic             pending;
  logic             pushTry, pushOk, popOk;

  always_comb begin
    popOk   = popReq && (count != '0);
    pushTry = loadHigh && pending;
    // A full queue still accepts a word when a pop frees a slot in the same cycle.
    pushOk  = pushTry && ((count != FULL_CNT) || popOk);
    strobes.latchLow    = loadLow;
    strobes.writeEn     = pushOk;
    strobes.readAdvance = popOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      count   <= '0;
    end else begin
      if (loadLow)       pending <= 1'b1;
      else if (loadHigh) pending <= 1'b0;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign txReady      = (count == '0);
  assign fifoFull     = (count == FULL_CNT);
  assign roomForBlock = (count < HALF_CNT);
endmodule

// File: rtl/txFifoData.sv
module txFifoData
  import txFifoPkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifoStrobe_t         strobes,
  input  logic [HALF_W-1:0]   hostData,
  input  logic                parityEven,
  input  logic                parityOn,
  output logic [2*HALF_W-1:0] headWord
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [HALF_W-1:0] lowHalf;
  logic [WORD_W-1:0] rawWord, commitWord;
  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              parityBit;

  always_comb begin
    rawWord = {hostData, lowHalf};
    // Odd parity: set the top bit when the data bits hold an even number of ones.
    parityBit  = parityEven ? ^rawWord[WORD_W-2:0] : ~^rawWord[WORD_W-2:0];
    commitWord = parityOn ? {parityBit, rawWord[WORD_W-2:0]} : rawWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowHalf <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      if (strobes.latchLow)    lowHalf <= hostData;
      if (strobes.writeEn)     wrPtr   <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobes.readAdvance) rdPtr   <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.writeEn) store[wrPtr] <= commitWord;
  end

  assign headWord = store[rdPtr];
endmodule

// File: rtl/txParityFifo.sv
module txParityFifo
  import txFifoPkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [HALF_W-1:0]   hostData,
  input  logic                loadLow,
  input  logic                loadHigh,
  input  logic                parityEven,
  input  logic                parityOn,
  input  logic                popReq,
  output logic [2*HALF_W-1:0] txWord,
  output logic                txReady,
  output logic                roomForBlock,
  output logic                fifoFull
);
  fifoStrobe_t strobes;

  txFifoCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadLow(loadLow), .loadHigh(loadHigh),
    .popReq(popReq), .strobes(strobes), .txReady(txReady),
    .roomForBlock(roomForBlock), .fifoFull(fifoFull)
  );

  txFifoData #(.DEPTH(DEPTH), .HALF_W(HALF_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostData(hostData),
    .parityEven(parityEven), .parityOn(parityOn), .headWord(txWord)
  );
endmodule

// File: rtl/txParityFifoChk.sv
module txParityFifoChk (
  input logic clk,
  input logic rstN,
  input logic loadLow,
  input logic loadHigh,
  input logic popReq,
  input logic txReady,
  input logic roomForBlock,
  input logic fifoFull
);
  // R7: an empty queue and a full queue cannot be reported together.
  p_ready_full_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(txReady && fifoFull));

  // R8: a full queue never reports room for a block.
  p_full_no_room_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !roomForBlock);

  // R3: a commit attempt on a full queue without a pop leaves it full.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !popReq) |=> fifoFull);

  // R11: a pop on an empty queue with no commit attempt keeps it empty.
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && popReq && !loadHigh) |=> txReady);

  // R10: a low-half strobe on its own never moves any flag.
  p_low_only_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadLow && !loadHigh && !popReq) |=>
      ($stable(txReady) && $stable(fifoFull) && $stable(roomForBlock)));
endmodule

bind txParityFifo txParityFifoChk chk_i (.*);

// File: tb/txParityFifo_tb.sv
`timescale 1ns/1ps
module txParityFifo_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostData = '0;
  logic        loadLow = 1'b0, loadHigh = 1'b0, parityEven = 1'b0, parityOn = 1'b0, popReq = 1'b0;
  logic [31:0] txWord;
  logic        txReady, roomForBlock, fifoFull;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] model[$];

  always #5 clk = ~clk;

  txParityFifo dut_i (
    .clk(clk), .rstN(rstN), .hostData(hostData), .loadLow(loadLow),
    .loadHigh(loadHigh), .parityEven(parityEven), .parityOn(parityOn),
    .popReq(popReq), .txWord(txWord), .txReady(txReady),
    .roomForBlock(roomForBlock), .fifoFull(fifoFull)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [15:0] lo, input logic [15:0] hi,
                                          input logic on, input logic even);
    logic [31:0] w;
    w = {hi, lo};
    if (on) w[31] = even ? (^w[30:0]) : ~(^w[30:0]);
    return w;
  endfunction

  task automatic checkFlags(input string tag);
    int n;
    n = model.size();
    chk(txReady == (n == 0), {tag, " R7 txReady"}, 32'(txReady), 32'(n == 0));
    chk(roomForBlock == (n < 16), {tag, " R8 roomForBlock"}, 32'(roomForBlock), 32'(n < 16));
    chk(fifoFull == (n == 32), {tag, " R3 fifoFull"}, 32'(fifoFull), 32'(n == 32));
  endtask

  task automatic pushWord(input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk); loadLow = 1'b1; hostData = lo;
    @(negedge clk); loadLow = 1'b0; loadHigh = 1'b1; hostData = hi;
    @(negedge clk); loadHigh = 1'b0;
    if (model.size() < 32) model.push_back(expWord(lo, hi, parityOn, parityEven));
  endtask

  task automatic popWord(input string tag);
    logic [31:0] e;
    e = model.pop_front();
    chk(txWord == e, {tag, " R9 head word"}, txWord, e);
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
  endtask

  task automatic testReset();
    chk(txReady == 1'b1, "R1 txReady after reset", 32'(txReady), 32'd1);
    chk(roomForBlock == 1'b1, "R1 roomForBlock after reset", 32'(roomForBlock), 32'd1);
    chk(fifoFull == 1'b0, "R1 fifoFull after reset", 32'(fifoFull), 32'd0);
  endtask

  task automatic testAssembly();
    parityOn = 1'b0;
    pushWord(16'h1234, 16'hABCD);
    chk(txWord == 32'hABCD1234, "R2 R6 assembled word", txWord, 32'hABCD1234);
    checkFlags("assembly");
    popWord("assembly");
    checkFlags("assembly drained");
  endtask

  task automatic testParity();
    parityOn = 1'b1; parityEven = 1'b0;
    pushWord(16'h0001, 16'h0000);
    pushWord(16'h0003, 16'h8000);
    parityEven = 1'b1;
    pushWord(16'h0001, 16'h0000);
    pushWord(16'h0003, 16'h8000);
    for (int i = 0; i < 2; i++) begin
      chk(^txWord == 1'b1, "R4 odd parity count", 32'(^txWord), 32'd1);
      popWord("R4 odd");
    end
    for (int i = 0; i < 2; i++) begin
      chk(^txWord == 1'b0, "R5 even parity count", 32'(^txWord), 32'd0);
      popWord("R5 even");
    end
    parityOn = 1'b0;
    pushWord(16'h0001, 16'h8000);
    chk(txWord == 32'h80000001, "R6 parity off keeps bit 31", txWord, 32'h80000001);
    popWord("R6");
  endtask

  task automatic testStrobes();
    @(negedge clk); loadHigh = 1'b1; hostData = 16'h5555;
    @(negedge clk); loadHigh = 1'b0;
    checkFlags("R10 orphan high");
    @(negedge clk); loadLow = 1'b1; hostData = 16'h1111;
    @(negedge clk); hostData = 16'h2222;
    @(negedge clk); loadLow = 1'b0; loadHigh = 1'b1; hostData = 16'h3333;
    @(negedge clk); loadHigh = 1'b0;
    model.push_back(32'h33332222);
    chk(txWord == 32'h33332222, "R10 low half overwritten", txWord, 32'h33332222);
    popWord("R10");
  endtask

  task automatic testEmptyPop();
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
    checkFlags("R11 empty pop");
    pushWord(16'h0F0F, 16'h7070);
    chk(txWord == 32'h70700F0F, "R11 queue sane after empty pop", txWord, 32'h70700F0F);
    popWord("R11");
    checkFlags("R11 drained");
  endtask

  task automatic testFillAndFull();
    parityOn = 1'b0;
    for (int i = 0; i < 32; i++) begin
      pushWord(16'(i * 37 + 5), 16'(16'h4000 ^ (i * 11)));
      checkFlags($sformatf("fill %0d", i + 1));
    end
    pushWord(16'hDEAD, 16'hBEEF);
    checkFlags("R3 overflow attempt");
    @(negedge clk); loadLow = 1'b1; hostData = 16'hCAFE;
    @(negedge clk); loadLow = 1'b0; loadHigh = 1'b1; popReq = 1'b1; hostData = 16'h0BAD;
    @(negedge clk); loadHigh = 1'b0; popReq = 1'b0;
    void'(model.pop_front());
    model.push_back(32'h0BADCAFE);
    chk(fifoFull == 1'b1, "R12 full after push and pop", 32'(fifoFull), 32'd1);
    chk(txWord == model[0], "R12 head advanced", txWord, model[0]);
    for (int i = 0; i < 32; i++) popWord("R3 R12 drain order");
    checkFlags("drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAssembly();
    testParity();
    testStrobes();
    testEmptyPop();
    testFillAndFull();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule